// File: doc/BRIEF.md
# I2C Control Register Slave

This block is a two-wire serial slave that keeps the control settings of a video picture-improvement datapath. A bus master addresses it with a fixed 7-bit device address, names a register with a subaddress byte, and then writes or reads one or more bytes. The block runs on a system clock that oversamples the serial clock and data lines through synchronisers. It pulls the data line low through an open-drain enable and never stretches the clock.

Two 8-bit registers live at subaddresses 0x10 and 0x11. Their fields drive parallel outputs: luminance delay select, sandcastle level select and colour transient enable from the first register; coring enable, peaking delay enable, low peaking centre frequency and a two-bit peaking gain from the second. After reset both registers hold 0x01. Subaddresses outside the pair, the general call and any other device address get no acknowledge and leave the registers untouched.

Top module: `vctl_i2c_regs`

## Requirements
- R1: Only the address byte 0x88 (device address 1000100, bit 0 = 0 write) and 0x89 (bit 0 = 1 read) are acknowledged; the general call 0x00 and any other address get no ACK, and the bytes that follow in that transfer do not change the registers.
- R2: After reset both registers read 0x01 (bit 0 set, bits 7..1 clear) and SDA is not driven.
- R3: In a write, the subaddress byte is acknowledged only when it is 0x10 or 0x11; any other value gets no ACK and the data bytes that follow leave the registers unchanged.
- R4: Each data byte of a write is acknowledged, stored at the current subaddress, and the subaddress then moves up by one, so consecutive bytes fill 0x10 then 0x11.
- R5: A data byte arriving when the subaddress has moved past 0x11 gets no ACK and changes no register.
- R6: Register 0x10 bit 7 and register 0x11 bits 4..2 always read 0, whatever is written.
- R7: Field outputs: from 0x10, bit 6 is the 5 V sandcastle select, bit 5 the transient-improvement enable, bits 4..0 the delay select; from 0x11, bit 7 the coring enable, bit 6 the peaking delay enable, bit 5 the low centre-frequency select, bits 1..0 the peaking gain code.
- R8: A read returns the register at the current subaddress MSB first, then moves the subaddress up by one for each byte; a subaddress outside 0x10..0x11 reads 0xFF; a master NACK leaves SDA released until the next START.
- R9: A START, including a repeated START in the middle of a transfer, makes the next byte an address byte; START and STOP both release SDA.
- R10: The slave only begins to pull SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| lvl5_sel_o | output | 1 | Sandcastle 5 V level select |
| cti_en_o | output | 1 | Colour transient improvement enable |
| dly_sel_o | output | 5 | Luminance delay select |
| core_en_o | output | 1 | Coring enable |
| pk_dly_en_o | output | 1 | Peaking delay enable |
| pk_lowf_o | output | 1 | Low peaking centre frequency select |
| pk_gain_o | output | 2 | Peaking gain code |

## Verification
On every cycle the assertions check that the slave starts pulling SDA only with SCL low, that START and STOP release the line, that the registers hold still unless a write strobe fires, and that the fixed-zero bits stay zero. Address and subaddress filtering, auto-increment across the pair, the stop past 0x11, read ordering with the 0xFF filler and the end of a read on NACK can only be shown by the bench's bus transfers, which compare acknowledges, read bytes and field outputs with values derived from the requirements.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WR,
    PH_RD
  } phase_t;

  localparam logic [7:0] REG_RST = 8'h01;

  // bits that may hold a one, per register slot
  function automatic logic [7:0] keep_mask(input int unsigned idx);
    case (idx)
      0:       return 8'h7F;
      1:       return 8'hE3;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/vctl_sync.sv
module vctl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '1;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '1;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/vctl_busev.sv
module vctl_busev (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic rise,
  output logic fall,
  output logic start,
  output logic stop
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign rise  = scl & ~scl_d;
  assign fall  = ~scl & scl_d;
  assign start = scl & scl_d & sda_d & ~sda;
  assign stop  = scl & scl_d & ~sda_d & sda;

endmodule

// File: rtl/vctl_engine.sv
module vctl_engine
  import vctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter logic [7:0] BASE_SUB = 8'h10,
  parameter int         NUM_REGS = 2,
  parameter int         IW       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          start,
  input  logic          stop,
  input  logic          sda,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] idx_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);

  localparam logic [8:0] LIMIT = {1'b0, BASE_SUB} + 9'(NUM_REGS);

  function automatic logic in_win(input logic [7:0] v);
    return ({1'b0, v} >= {1'b0, BASE_SUB}) && ({1'b0, v} < LIMIT);
  endfunction

  phase_t     phase, phase_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] shreg, sh_n;
  logic [7:0] ptr, ptr_n;
  logic [7:0] obyte, ob_n;
  logic       rw, rw_n;
  logic       nack, nack_n;
  logic       oe, oe_n;
  logic       we;
  logic [7:0] rd_byte;

  assign rd_byte = in_win(ptr) ? rd_data : 8'hFF;

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    sh_n    = shreg;
    ptr_n   = ptr;
    ob_n    = obyte;
    rw_n    = rw;
    nack_n  = nack;
    oe_n    = oe;
    we      = 1'b0;
    if (start) begin
      phase_n = PH_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else if (stop) begin
      phase_n = PH_IDLE;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else if (phase != PH_IDLE) begin
      if (rise) begin
        if (cnt < 4'd8 && phase != PH_RD) sh_n = {shreg[6:0], sda};
        if (cnt == 4'd8 && phase == PH_RD) nack_n = sda;
        if (cnt < 4'd9) cnt_n = cnt + 4'd1;
      end else if (fall) begin
        if (cnt == 4'd8) begin
          case (phase)
            PH_ADDR: if (shreg[7:1] == DEV_ADDR) begin
                       oe_n = 1'b1;
                       rw_n = shreg[0];
                     end else phase_n = PH_IDLE;
            PH_SUB:  if (in_win(shreg)) begin
                       oe_n  = 1'b1;
                       ptr_n = shreg;
                     end else phase_n = PH_IDLE;
            PH_WR:   if (in_win(ptr)) begin
                       oe_n  = 1'b1;
                       we    = 1'b1;
                       ptr_n = ptr + 8'd1;
                     end else phase_n = PH_IDLE;
            default: oe_n = 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt_n = 4'd0;
          oe_n  = 1'b0;
          case (phase)
            PH_ADDR: if (rw) begin
                       phase_n = PH_RD;
                       oe_n    = ~rd_byte[7];
                       ob_n    = {rd_byte[6:0], 1'b1};
                       ptr_n   = ptr + 8'd1;
                     end else phase_n = PH_SUB;
            PH_SUB:  phase_n = PH_WR;
            PH_RD:   if (nack) phase_n = PH_IDLE;
                     else begin
                       oe_n  = ~rd_byte[7];
                       ob_n  = {rd_byte[6:0], 1'b1};
                       ptr_n = ptr + 8'd1;
                     end
            default: phase_n = phase;
          endcase
        end else if (phase == PH_RD && cnt != 4'd0) begin
          oe_n = ~obyte[7];
          ob_n = {obyte[6:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= 4'd0;
      shreg <= 8'd0;
      ptr   <= 8'd0;
      obyte <= 8'hFF;
      rw    <= 1'b0;
      nack  <= 1'b0;
      oe    <= 1'b0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      shreg <= sh_n;
      ptr   <= ptr_n;
      obyte <= ob_n;
      rw    <= rw_n;
      nack  <= nack_n;
      oe    <= oe_n;
    end
  end

  assign idx_o    = IW'(ptr - BASE_SUB);
  assign we_o     = we;
  assign wdata_o  = shreg;
  assign sda_oe_o = oe;

endmodule

// File: rtl/vctl_regfile.sv
module vctl_regfile
  import vctl_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int IW       = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IW-1:0]         idx,
  input  logic [7:0]            wdata,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [7:0]            rd_data
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0]    KEEP = keep_mask(i);
    localparam logic [IW-1:0] SLOT = IW'(i);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= REG_RST & KEEP;
      else if (we && idx == SLOT) q <= wdata & KEEP;
    end
    assign regs_o[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx == IW'(k)) rd_data = regs_o[k*8 +: 8];
  end

endmodule

// File: rtl/vctl_i2c_regs.sv
module vctl_i2c_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter logic [7:0] BASE_SUB    = 8'h10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       lvl5_sel_o,
  output logic       cti_en_o,
  output logic [4:0] dly_sel_o,
  output logic       core_en_o,
  output logic       pk_dly_en_o,
  output logic       pk_lowf_o,
  output logic [1:0] pk_gain_o
);

  localparam int NUM_REGS = 2;
  localparam int IW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic          scl_s, sda_s;
  logic          bus_rise, bus_fall, bus_start, bus_stop;
  logic [IW-1:0] reg_idx;
  logic          reg_we;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [NUM_REGS*8-1:0] reg_flat;

  vctl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  vctl_busev u_busev (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .rise(bus_rise), .fall(bus_fall), .start(bus_start), .stop(bus_stop)
  );

  vctl_engine #(
    .DEV_ADDR(DEV_ADDR), .BASE_SUB(BASE_SUB), .NUM_REGS(NUM_REGS), .IW(IW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .rise(bus_rise), .fall(bus_fall),
    .start(bus_start), .stop(bus_stop), .sda(sda_s), .rd_data(reg_rdata),
    .idx_o(reg_idx), .we_o(reg_we), .wdata_o(reg_wdata), .sda_oe_o(sda_oe_o)
  );

  vctl_regfile #(.NUM_REGS(NUM_REGS), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx),
    .wdata(reg_wdata), .regs_o(reg_flat), .rd_data(reg_rdata)
  );

  assign lvl5_sel_o  = reg_flat[6];
  assign cti_en_o    = reg_flat[5];
  assign dly_sel_o   = reg_flat[4:0];
  assign core_en_o   = reg_flat[15];
  assign pk_dly_en_o = reg_flat[14];
  assign pk_lowf_o   = reg_flat[13];
  assign pk_gain_o   = reg_flat[9:8];

endmodule

// File: rtl/vctl_i2c_chk.sv
module vctl_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start,
  input logic        stop,
  input logic        sda_oe,
  input logic        we,
  input logic [15:0] regs
);

  // R10
  drive_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R9
  release_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop) |=> !sda_oe);

  // R4
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));

  // R6
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[7] && (regs[12:10] == 3'b000));

endmodule

bind vctl_i2c_regs vctl_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start(bus_start),
  .stop(bus_stop), .sda_oe(sda_oe_o), .we(reg_we), .regs(reg_flat)
);

// File: tb/sim_vctl_i2c_regs.sv
module sim_vctl_i2c_regs;

  localparam int Q = 8;

  logic       clk, rst_n, scl, sda_m;
  logic       sda_oe, lvl5, cti, core, pkdly, lowf;
  logic [4:0] dly;
  logic [1:0] gain;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  vctl_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .lvl5_sel_o(lvl5), .cti_en_o(cti), .dly_sel_o(dly),
    .core_en_o(core), .pk_dly_en_o(pkdly), .pk_lowf_o(lowf), .pk_gain_o(gain)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] r0();
    return {1'b0, lvl5, cti, dly};
  endfunction
  function automatic logic [7:0] r1();
    return {core, pkdly, lowf, 3'b000, gain};
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wq();
    scl = 1'b1; wq();
    seen = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  task automatic t_reset();
    chk("R2 reg10 reset", r0(), 8'h01);
    chk("R2 reg11 reset", r1(), 8'h01);
    chk("R2 sda idle", sda_oe, 1'b0);
  endtask

  task automatic t_write_single();
    logic a;
    bus_start();
    send_byte(8'h88, a); chk("R1 address ack", a, 1'b1);
    send_byte(8'h10, a); chk("R3 sub 0x10 ack", a, 1'b1);
    send_byte(8'h6A, a); chk("R4 data ack", a, 1'b1);
    bus_stop(); wq();
    chk("R7 sandcastle sel", lvl5, 1'b1);
    chk("R7 cti enable", cti, 1'b1);
    chk("R7 delay select", dly, 5'h0A);
    chk("R4 reg11 untouched", r1(), 8'h01);
    chk("R9 released after stop", sda_oe, 1'b0);
  endtask

  task automatic t_autoinc();
    logic a;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h10, a);
    send_byte(8'h15, a); chk("R4 first ack", a, 1'b1);
    send_byte(8'hC2, a); chk("R4 second ack", a, 1'b1);
    send_byte(8'h3C, a); chk("R5 past end nack", a, 1'b0);
    bus_stop(); wq();
    chk("R4 reg10", r0(), 8'h15);
    chk("R5 reg11 kept", r1(), 8'hC2);
    chk("R7 coring", core, 1'b1);
    chk("R7 peak delay", pkdly, 1'b1);
    chk("R7 low freq", lowf, 1'b0);
    chk("R7 gain", gain, 2'b10);
  endtask

  task automatic t_bad_sub();
    logic a;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h05, a); chk("R3 sub 0x05 nack", a, 1'b0);
    send_byte(8'hFF, a); chk("R3 data after bad sub nack", a, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h12, a); chk("R3 sub 0x12 nack", a, 1'b0);
    send_byte(8'hFF, a);
    bus_stop(); wq();
    chk("R3 reg10 unchanged", r0(), 8'h15);
    chk("R3 reg11 unchanged", r1(), 8'hC2);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'h00, a); chk("R1 general call nack", a, 1'b0);
    send_byte(8'h10, a);
    send_byte(8'h00, a);
    bus_stop();
    bus_start();
    send_byte(8'h8A, a); chk("R1 other address nack", a, 1'b0);
    send_byte(8'h11, a);
    send_byte(8'h00, a);
    bus_stop(); wq();
    chk("R1 reg10 unchanged", r0(), 8'h15);
    chk("R1 reg11 unchanged", r1(), 8'hC2);
  endtask

  task automatic t_fixed();
    logic a;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h10, a);
    send_byte(8'hFF, a);
    send_byte(8'hFF, a);
    bus_stop(); wq();
    chk("R6 reg10 bit7 zero", r0(), 8'h7F);
    chk("R6 reg11 bits4..2 zero", r1(), 8'hE3);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte(8'h89, a); chk("R9 read address after restart", a, 1'b1);
    recv_byte(1'b1, v);  chk("R8 read reg10", v, 8'h7F);
    recv_byte(1'b0, v);  chk("R8 read reg11", v, 8'hE3);
    wq();
    chk("R8 released after nack", sda_oe, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h11, a);
    bus_start();
    send_byte(8'h89, a);
    recv_byte(1'b1, v); chk("R8 read from 0x11", v, 8'hE3);
    recv_byte(1'b1, v); chk("R8 past end reads 0xFF", v, 8'hFF);
    recv_byte(1'b0, v); chk("R8 still 0xFF", v, 8'hFF);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h10, a);
    send_byte(8'h21, a);
    bus_start();
    send_byte(8'h88, a); chk("R9 restart treated as address", a, 1'b1);
    send_byte(8'h11, a); chk("R9 sub after restart", a, 1'b1);
    send_byte(8'h41, a);
    bus_stop(); wq();
    chk("R9 reg10", r0(), 8'h21);
    chk("R9 reg11", r1(), 8'h41);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    scl   = 1'b1;
    sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    t_reset();
    t_write_single();
    t_autoinc();
    t_bad_sub();
    t_bad_addr();
    t_fixed();
    t_read();
    t_restart();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule